// File: doc/BRIEF.md
# Multi-Size Set-Associative Translation Cache

This block is an address translation cache that holds page table walker results for three mapping sizes: 4 KiB, 64 KiB and 1 MiB. Storage is 8 ways by 64 sets. A lookup port takes a virtual address and, one cycle later, returns a hit flag, the translated physical address and the size of the mapping that matched. A fill port writes a walker result into the cache. Two invalidation commands are provided: one empties the whole cache, and one removes the entries in one set that cover a given 4 KiB page.

The set is always chosen by the address bits just above the 4 KiB page offset, whatever the mapping size. A 64 KiB mapping may therefore be held in any of 16 neighbouring sets, and a 1 MiB mapping in any set. To remove a large mapping completely, software sends one per-page command for each set the mapping may occupy: 16 commands for 64 KiB and 64 commands for 1 MiB. Each entry records its size, and the tag compare uses only the address bits above that size.

Victim choice first takes a free way. When the set is full it takes the least recently used way if the recency option is on, and otherwise follows a round-robin pointer kept for each set.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every way is empty, so every lookup returns rsp_hit=0 and rsp_fault=0.
- R2: A lookup sampled at a clock edge gives rsp_valid=1 for the following cycle, together with rsp_hit, rsp_pa and rsp_size. Size codes are 0 for 4 KiB, 1 for 64 KiB and 2 for 1 MiB. rsp_pa is the stored frame with the low address bits taken from the lookup address: bits [11:0] for code 0, [15:0] for code 1 and [19:0] for code 2.
- R3: The set is VA[17:12] for fills, lookups and per-page invalidations. A valid entry matches only when its stored page number equals the lookup page number in the bits above its size: VA[31:12] for code 0, VA[31:16] for code 1 and VA[31:20] for code 2.
- R4: When more than one valid way in the set matches, the response has rsp_fault=1 and rsp_hit=0, and no way is marked as used.
- R5: flush_all empties every way of every set. A lookup sampled at the next edge misses.
- R6: A per-page command is inv_wr with inv_cmd[31:12] holding the page and inv_cmd[0]=1. It empties every way in set inv_cmd[17:12] whose mapping covers that page. Ways in other sets are left alone. A command with inv_cmd[0]=0 has no effect.
- R7: A fill goes into the lowest-numbered empty way of its set. A fill with size code 3 is ignored.
- R8: With lru_en=1, a fill into a full set replaces the least recently used way. A fill, or a lookup that hits exactly one way, counts as a use.
- R9: With lru_en=0, a fill into a full set replaces the way selected by that set's pointer. The pointer starts at 0 and advances by one, wrapping, at each such replacement.
- R10: A fill is dropped when flush_all is asserted in the same cycle, or when a valid per-page command targets the same set in the same cycle. A fill to a different set from the command still takes effect.
- R11: When a fill is accepted in the same cycle as a single-way lookup hit, only the fill updates recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lru_en | input | 1 | 1: least-recently-used replacement; 0: per-set round-robin |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Response for the lookup sampled at the previous edge |
| rsp_hit | output | 1 | Exactly one way matched |
| rsp_fault | output | 1 | More than one way matched |
| rsp_pa | output | 32 | Translated physical address |
| rsp_size | output | 2 | Size code of the matching mapping |
| fill_valid | input | 1 | Fill request from the walker |
| fill_va | input | 32 | Virtual address of the fill |
| fill_pa | input | 32 | Physical address of the fill |
| fill_size | input | 2 | Size code of the fill (3 is ignored) |
| flush_all | input | 1 | Empty the whole cache |
| inv_wr | input | 1 | Per-page invalidation strobe |
| inv_cmd | input | 32 | Page in [31:12], valid flag in [0] |

## Verification
Each lookup is answered in the cycle after the edge that samples it. Fills and invalidations act on the same edge, so a lookup sampled at the next edge already sees their effect. The bench drives every request at the falling edge, holds it across exactly one rising edge, and reads the registered response one nanosecond after that edge. Each step therefore compares the response for the lookup it issued itself. The expected response comes from the cache state before that edge, while the bench's own model of the fill, invalidation and recency effects of the step is applied after it, in the order the requirements fix.

// File: rtl/xtlb_pkg.sv
`timescale 1ns/1ps
package xtlb_pkg;
   typedef logic [1:0] pg_sz_t;
   localparam pg_sz_t SZ_SMALL = 2'd0;
   localparam pg_sz_t SZ_MID   = 2'd1;
   localparam pg_sz_t SZ_BIG   = 2'd2;
   localparam pg_sz_t SZ_RSVD  = 2'd3;
endpackage

// File: rtl/xlat_tlb_match.sv
`timescale 1ns/1ps
// Per-way coverage compare: each way checks only the page-number bits
// above the size it holds.
module xlat_tlb_match
   import xtlb_pkg::*;
#(
   parameter int WAYS     = 8,
   parameter int VPN_W    = 20,
   parameter int MID_BITS = 4,
   parameter int BIG_BITS = 8
) (
   input  logic [WAYS-1:0]             vld,
   input  logic [WAYS-1:0][VPN_W-1:0]  tags,
   input  logic [WAYS-1:0][1:0]        sizes,
   input  logic [VPN_W-1:0]            vpn,
   output logic [WAYS-1:0]             hits
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic eq_small, eq_mid, eq_big;
      assign eq_small = (tags[w] == vpn);
      assign eq_mid   = (tags[w][VPN_W-1:MID_BITS] == vpn[VPN_W-1:MID_BITS]);
      assign eq_big   = (tags[w][VPN_W-1:BIG_BITS] == vpn[VPN_W-1:BIG_BITS]);
      assign hits[w]  = vld[w] & (((sizes[w] == SZ_SMALL) & eq_small) |
                                  ((sizes[w] == SZ_MID)   & eq_mid)   |
                                  ((sizes[w] == SZ_BIG)   & eq_big));
   end
endmodule

// File: rtl/xlat_tlb_age.sv
`timescale 1ns/1ps
// Recency ranks: the touched way becomes rank 0, ways younger than it age by one.
module xlat_tlb_age #(
   parameter int WAYS  = 8,
   parameter int AGE_W = 3
) (
   input  logic [WAYS-1:0][AGE_W-1:0] ages,
   input  logic [AGE_W-1:0]           touch,
   output logic [WAYS-1:0][AGE_W-1:0] nxt
);
   logic [AGE_W-1:0] pivot;
   assign pivot = ages[touch];
   for (genvar w = 0; w < WAYS; w++) begin : g_rank
      assign nxt[w] = (touch == AGE_W'(w)) ? '0 :
                      (ages[w] < pivot)    ? ages[w] + 1'b1 : ages[w];
   end
endmodule

// File: rtl/xlat_tlb_victim.sv
`timescale 1ns/1ps
// Victim choice: lowest free way, else oldest rank or round-robin pointer.
module xlat_tlb_victim #(
   parameter int WAYS  = 8,
   parameter int WAY_W = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [WAYS-1:0]            vld,
   input  logic [WAYS-1:0][WAY_W-1:0] ages,
   input  logic [WAY_W-1:0]           rr_ptr,
   input  logic                       lru_en,
   output logic [WAY_W-1:0]           victim,
   output logic                       rr_adv
);
   logic [WAYS-1:0]  oldest;
   logic [WAY_W-1:0] free_way, old_way;
   logic             has_free;

   for (genvar w = 0; w < WAYS; w++) begin : g_old
      assign oldest[w] = (ages[w] == WAY_W'(WAYS-1));
   end

   always_comb begin
      free_way = '0;
      has_free = 1'b0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (!vld[w]) begin
            free_way = WAY_W'(w);
            has_free = 1'b1;
         end
      end
      old_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (oldest[w]) old_way = WAY_W'(w);
      end
   end

   assign victim = has_free ? free_way : (lru_en ? old_way : rr_ptr);
   assign rr_adv = !has_free && !lru_en;

   AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest) == 1);  // R8
endmodule

// File: rtl/xlat_tlb.sv
`timescale 1ns/1ps
module xlat_tlb
   import xtlb_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PA_W       = 32,
   parameter int WAYS       = 8,
   parameter int SETS       = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int MID_SHIFT  = 16,
   parameter int BIG_SHIFT  = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lru_en,
   input  logic            lk_valid,
   input  logic [VA_W-1:0] lk_va,
   output logic            rsp_valid,
   output logic            rsp_hit,
   output logic            rsp_fault,
   output logic [PA_W-1:0] rsp_pa,
   output logic [1:0]      rsp_size,
   input  logic            fill_valid,
   input  logic [VA_W-1:0] fill_va,
   input  logic [PA_W-1:0] fill_pa,
   input  logic [1:0]      fill_size,
   input  logic            flush_all,
   input  logic            inv_wr,
   input  logic [VA_W-1:0] inv_cmd
);
   localparam int VPN_W    = VA_W - PAGE_SHIFT;
   localparam int PPN_W    = PA_W - PAGE_SHIFT;
   localparam int IDX_W    = $clog2(SETS);
   localparam int WAY_W    = $clog2(WAYS);
   localparam int MID_BITS = MID_SHIFT - PAGE_SHIFT;
   localparam int BIG_BITS = BIG_SHIFT - PAGE_SHIFT;

   initial begin : p_param_check
      assert ((1 << IDX_W) == SETS) else $error("SETS must be a power of two");
      assert ((1 << WAY_W) == WAYS && WAYS >= 2) else $error("WAYS must be a power of two, at least 2");
      assert (PAGE_SHIFT >= 1 && MID_SHIFT > PAGE_SHIFT && BIG_SHIFT > MID_SHIFT) else $error("size shifts must ascend");
      assert (BIG_SHIFT <= VA_W && BIG_SHIFT <= PA_W) else $error("largest size exceeds address width");
      assert (IDX_W <= VPN_W) else $error("set index wider than page number");
   end

   // ---------------- storage ----------------
   logic [WAYS-1:0]             vld_q [SETS];
   logic [WAYS-1:0][VPN_W-1:0]  tag_q [SETS];
   logic [WAYS-1:0][PPN_W-1:0]  ppn_q [SETS];
   logic [WAYS-1:0][1:0]        sz_q  [SETS];
   logic [WAYS-1:0][WAY_W-1:0]  age_q [SETS];
   logic [WAY_W-1:0]            rr_q  [SETS];

   // ---------------- decode ----------------
   logic [VPN_W-1:0] lk_vpn, fill_vpn, inv_vpn;
   logic [IDX_W-1:0] lk_set, fill_set, inv_set, touch_set;
   logic [PPN_W-1:0] fill_ppn;
   logic             inv_go;

   assign lk_vpn   = lk_va[VA_W-1:PAGE_SHIFT];
   assign fill_vpn = fill_va[VA_W-1:PAGE_SHIFT];
   assign inv_vpn  = inv_cmd[VA_W-1:PAGE_SHIFT];
   assign fill_ppn = fill_pa[PA_W-1:PAGE_SHIFT];
   assign lk_set   = lk_vpn[IDX_W-1:0];
   assign fill_set = fill_vpn[IDX_W-1:0];
   assign inv_set  = inv_vpn[IDX_W-1:0];
   assign inv_go   = inv_wr & inv_cmd[0];

   // ---------------- match ----------------
   logic [WAYS-1:0] lk_hits, inv_hits;

   xlat_tlb_match #(.WAYS(WAYS), .VPN_W(VPN_W), .MID_BITS(MID_BITS), .BIG_BITS(BIG_BITS)) u_lk_match (
      .vld(vld_q[lk_set]), .tags(tag_q[lk_set]), .sizes(sz_q[lk_set]),
      .vpn(lk_vpn), .hits(lk_hits));

   xlat_tlb_match #(.WAYS(WAYS), .VPN_W(VPN_W), .MID_BITS(MID_BITS), .BIG_BITS(BIG_BITS)) u_inv_match (
      .vld(vld_q[inv_set]), .tags(tag_q[inv_set]), .sizes(sz_q[inv_set]),
      .vpn(inv_vpn), .hits(inv_hits));

   logic             lk_single, lk_multi, lk_touch;
   logic [WAY_W-1:0] lk_way;

   always_comb begin
      lk_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (lk_hits[w]) lk_way = WAY_W'(w);
      end
   end
   assign lk_single = ($countones(lk_hits) == 1);
   assign lk_multi  = ($countones(lk_hits) > 1);
   assign lk_touch  = lk_valid & lk_single;

   // ---------------- replacement ----------------
   logic [WAY_W-1:0] fill_way, touch_way;
   logic             fill_rr_adv, fill_ok, touch_en;
   logic [WAYS-1:0][WAY_W-1:0] age_nxt;

   xlat_tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
      .clk(clk), .rst_n(rst_n),
      .vld(vld_q[fill_set]), .ages(age_q[fill_set]), .rr_ptr(rr_q[fill_set]),
      .lru_en(lru_en), .victim(fill_way), .rr_adv(fill_rr_adv));

   assign fill_ok = fill_valid && (fill_size != SZ_RSVD) && !flush_all &&
                    !(inv_go && (inv_set == fill_set));

   // One recency update per cycle; an accepted fill wins over a lookup hit.
   assign touch_en  = fill_ok | lk_touch;
   assign touch_set = fill_ok ? fill_set : lk_set;
   assign touch_way = fill_ok ? fill_way : lk_way;

   xlat_tlb_age #(.WAYS(WAYS), .AGE_W(WAY_W)) u_age (
      .ages(age_q[touch_set]), .touch(touch_way), .nxt(age_nxt));

   // ---------------- state update ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            rr_q[s]  <= '0;
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end
      end else begin
         if (flush_all) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
         end else if (inv_go) begin
            vld_q[inv_set] <= vld_q[inv_set] & ~inv_hits;
         end
         if (fill_ok) vld_q[fill_set][fill_way] <= 1'b1;
         if (touch_en) age_q[touch_set] <= age_nxt;
         if (fill_ok && fill_rr_adv) rr_q[fill_set] <= rr_q[fill_set] + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_ok) begin
         tag_q[fill_set][fill_way] <= fill_vpn;
         ppn_q[fill_set][fill_way] <= fill_ppn;
         sz_q[fill_set][fill_way]  <= fill_size;
      end
   end

   // ---------------- response ----------------
   logic [PPN_W-1:0] sel_ppn;
   logic [1:0]       sel_sz;
   logic [PA_W-1:0]  sel_pa;

   assign sel_ppn = ppn_q[lk_set][lk_way];
   assign sel_sz  = sz_q[lk_set][lk_way];

   always_comb begin
      case (sel_sz)
         SZ_MID:  sel_pa = {sel_ppn[PPN_W-1:MID_BITS], lk_va[MID_SHIFT-1:0]};
         SZ_BIG:  sel_pa = {sel_ppn[PPN_W-1:BIG_BITS], lk_va[BIG_SHIFT-1:0]};
         default: sel_pa = {sel_ppn, lk_va[PAGE_SHIFT-1:0]};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_pa    <= '0;
         rsp_size  <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid & lk_single;
         rsp_fault <= lk_valid & lk_multi;
         rsp_pa    <= sel_pa;
         rsp_size  <= sel_sz;
      end
   end

   // ---------------- assertions ----------------
   logic any_valid;
   always_comb begin
      any_valid = 1'b0;
      for (int s = 0; s < SETS; s++) any_valid = any_valid | (|vld_q[s]);
   end

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);  // R2
   AST_HIT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_fault));  // R4
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !any_valid);  // R5
   AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      inv_go |=> ((vld_q[$past(inv_set)] & $past(inv_hits)) == '0));  // R6
   AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_ok |=> vld_q[$past(fill_set)][$past(fill_way)]);  // R7
   AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_ok && fill_rr_adv) |=> rr_q[$past(fill_set)] == WAY_W'($past(rr_q[fill_set]) + 1'b1));  // R9
   AST_FILL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && inv_go && (inv_set == fill_set) && !flush_all) |=>
      (vld_q[$past(fill_set)] == ($past(vld_q[fill_set]) & ~$past(inv_hits))));  // R10
endmodule

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lru_en = 1'b1;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_va = '0;
   logic        rsp_valid, rsp_hit, rsp_fault;
   logic [31:0] rsp_pa;
   logic [1:0]  rsp_size;
   logic        fill_valid = 1'b0;
   logic [31:0] fill_va = '0, fill_pa = '0;
   logic [1:0]  fill_size = '0;
   logic        flush_all = 1'b0;
   logic        inv_wr = 1'b0;
   logic [31:0] inv_cmd = '0;

   always #2.5 clk = ~clk;

   xlat_tlb uut (.*);

   int checks = 0, failures = 0;
   bit done = 0;

   // ---------------- reference model ----------------
   bit          m_v   [64][8];
   logic [19:0] m_tag [64][8];
   logic [19:0] m_ppn [64][8];
   logic [1:0]  m_sz  [64][8];
   int          m_age [64][8];
   int          m_rr  [64];

   bit          e_hit, e_fault, e_both;
   logic [31:0] e_pa;
   logic [1:0]  e_sz;
   bit          a_valid, a_hit, a_fault;
   logic [31:0] a_pa;
   logic [1:0]  a_sz;

   function automatic void m_reset();
      for (int s = 0; s < 64; s++) begin
         m_rr[s] = 0;
         for (int w = 0; w < 8; w++) begin m_v[s][w] = 0; m_age[s][w] = w; end
      end
   endfunction

   function automatic bit m_cov(int s, int w, logic [19:0] vpn);
      if (!m_v[s][w]) return 0;
      case (m_sz[s][w])
         2'd0: return vpn == m_tag[s][w];
         2'd1: return vpn[19:4] == m_tag[s][w][19:4];
         2'd2: return vpn[19:8] == m_tag[s][w][19:8];
         default: return 0;
      endcase
   endfunction

   function automatic void m_touch(int s, int tw);
      int old [8];
      for (int w = 0; w < 8; w++) old[w] = m_age[s][w];
      for (int w = 0; w < 8; w++)
         if (w == tw) m_age[s][w] = 0;
         else if (old[w] < old[tw]) m_age[s][w] = old[w] + 1;
   endfunction

   function automatic void chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endfunction

   task automatic step(input bit fv, input logic [31:0] fva, input logic [31:0] fpa, input logic [1:0] fsz,
                       input bit fa, input bit iw, input logic [31:0] ic,
                       input bit lv, input logic [31:0] lva);
      int ls, fs, is, cnt, lw, vic;
      bit igo, fok, radv, found;
      bit ih [8];
      @(negedge clk);
      fill_valid = fv; fill_va = fva; fill_pa = fpa; fill_size = fsz;
      flush_all = fa; inv_wr = iw; inv_cmd = ic; lk_valid = lv; lk_va = lva;
      // expectation from state before the edge
      ls = int'(lva[17:12]); fs = int'(fva[17:12]); is = int'(ic[17:12]);
      cnt = 0; lw = 0;
      for (int w = 0; w < 8; w++) if (m_cov(ls, w, lva[31:12])) begin cnt++; lw = w; end
      e_hit = lv && cnt == 1; e_fault = lv && cnt > 1;
      e_sz = m_sz[ls][lw];
      case (e_sz)
         2'd1: e_pa = {m_ppn[ls][lw][19:4], lva[15:0]};
         2'd2: e_pa = {m_ppn[ls][lw][19:8], lva[19:0]};
         default: e_pa = {m_ppn[ls][lw], lva[11:0]};
      endcase
      igo = iw && ic[0];
      fok = fv && fsz != 2'd3 && !fa && !(igo && is == fs);
      e_both = fok && e_hit;
      found = 0; vic = 0;
      for (int w = 7; w >= 0; w--) if (!m_v[fs][w]) begin vic = w; found = 1; end
      radv = !found && !lru_en;
      if (!found) begin
         if (lru_en) begin for (int w = 0; w < 8; w++) if (m_age[fs][w] == 7) vic = w; end
         else vic = m_rr[fs];
      end
      for (int w = 0; w < 8; w++) ih[w] = m_cov(is, w, ic[31:12]);
      // apply the edge
      if (fa) begin for (int s = 0; s < 64; s++) for (int w = 0; w < 8; w++) m_v[s][w] = 0; end
      else if (igo) begin for (int w = 0; w < 8; w++) if (ih[w]) m_v[is][w] = 0; end
      if (fok) begin
         m_v[fs][vic] = 1; m_tag[fs][vic] = fva[31:12]; m_ppn[fs][vic] = fpa[31:12]; m_sz[fs][vic] = fsz;
         m_touch(fs, vic);
         if (radv) m_rr[fs] = (m_rr[fs] + 1) % 8;
      end else if (e_hit) m_touch(ls, lw);
      @(posedge clk);
      #1;
      a_valid = rsp_valid; a_hit = rsp_hit; a_fault = rsp_fault; a_pa = rsp_pa; a_sz = rsp_size;
   endtask

   task automatic idle_inputs();
      @(negedge clk);
      fill_valid = 0; flush_all = 0; inv_wr = 0; lk_valid = 0;
   endtask

   task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
      step(1, va, pa, sz, 0, 0, 0, 0, 0);
   endtask
   task automatic flush();
      step(0, 0, 0, 0, 1, 0, 0, 0, 0);
   endtask
   task automatic inv(input logic [31:0] cmd);
      step(0, 0, 0, 0, 0, 1, cmd, 0, 0);
   endtask

   // explicit expectation, independent of the model
   task automatic expect_lk(input logic [31:0] va, input bit eh, input bit ef,
                            input logic [31:0] epa, input logic [1:0] esz, input string req);
      step(0, 0, 0, 0, 0, 0, 0, 1, va);
      chk(a_valid == 1, req, "rsp_valid", 32'(a_valid), 1);
      chk(a_hit == eh, req, "rsp_hit", 32'(a_hit), 32'(eh));
      chk(a_fault == ef, req, "rsp_fault", 32'(a_fault), 32'(ef));
      if (eh) begin
         chk(a_pa == epa, req, "rsp_pa", a_pa, epa);
         chk(a_sz == esz, req, "rsp_size", 32'(a_sz), 32'(esz));
      end
   endtask

   function automatic logic [31:0] sva(int k, int set);
      return (32'(k) << 18) | (32'(set) << 12);
   endfunction

   initial begin
      void'($urandom(32'd2718));
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1 chk(rsp_valid == 0 && rsp_hit == 0, "R1", "idle response after reset", 32'({rsp_valid, rsp_hit}), 0);

      // R1: empty after reset
      expect_lk(32'h1234_5678, 0, 0, 0, 0, "R1");
      expect_lk(32'h0000_0000, 0, 0, 0, 0, "R1");

      // R2 / R3: three sizes
      fill(32'h1234_5000, 32'hABCD_E000, 2'd0);
      expect_lk(32'h1234_5678, 1, 0, 32'hABCD_E678, 2'd0, "R2");
      fill(32'h0040_3000, 32'h8765_3000, 2'd1);
      expect_lk(32'h0040_3ABC, 1, 0, 32'h8765_3ABC, 2'd1, "R2");
      expect_lk(32'h0040_5ABC, 0, 0, 0, 0, "R3");
      expect_lk(32'h0041_3ABC, 0, 0, 0, 0, "R3");
      fill(32'h0127_A000, 32'h3000_0000, 2'd2);
      expect_lk(32'h0127_AFFF, 1, 0, 32'h3007_AFFF, 2'd2, "R2");
      expect_lk(32'h0120_0000, 0, 0, 0, 0, "R3");
      expect_lk(32'h01E7_A010, 0, 0, 0, 0, "R3");

      // R6: per-page invalidation
      inv(32'h0127_A000);
      expect_lk(32'h0127_A004, 1, 0, 32'h3007_A004, 2'd2, "R6");
      inv(32'h0120_0001);
      expect_lk(32'h0127_A008, 1, 0, 32'h3007_A008, 2'd2, "R6");
      inv(32'h0127_A001);
      expect_lk(32'h0127_A008, 0, 0, 0, 0, "R6");
      inv(32'h0040_3001);
      expect_lk(32'h0040_3ABC, 0, 0, 0, 0, "R6");
      expect_lk(32'h1234_5000, 1, 0, 32'hABCD_E000, 2'd0, "R6");

      // R4: overlapping mappings in one set
      fill(32'h0040_3000, 32'h1111_1000, 2'd0);
      fill(32'h0040_3000, 32'h2222_0000, 2'd1);
      expect_lk(32'h0040_3010, 0, 1, 0, 0, "R4");

      // R5: flush all
      flush();
      expect_lk(32'h1234_5678, 0, 0, 0, 0, "R5");
      expect_lk(32'h0040_3010, 0, 0, 0, 0, "R5");

      // R7: reserved size ignored
      fill(32'h0060_2000, 32'h5555_5000, 2'd3);
      expect_lk(32'h0060_2000, 0, 0, 0, 0, "R7");

      // R10: fill against invalidation
      step(1, 32'h0050_7000, 32'h6000_0000, 2'd0, 0, 1, 32'h0090_7001, 0, 0);
      expect_lk(32'h0050_7000, 0, 0, 0, 0, "R10");
      step(1, 32'h0050_8000, 32'h6000_1000, 2'd0, 1, 0, 0, 0, 0);
      expect_lk(32'h0050_8000, 0, 0, 0, 0, "R10");
      step(1, 32'h0050_9000, 32'h6000_2000, 2'd0, 0, 1, 32'h0090_7001, 0, 0);
      expect_lk(32'h0050_9044, 1, 0, 32'h6000_2044, 2'd0, "R10");

      // R8: least recently used replacement
      flush();
      lru_en = 1;
      for (int k = 0; k < 8; k++) fill(sva(k, 5), 32'hA000_0000 | (32'(k) << 12), 2'd0);
      expect_lk(sva(0, 5), 1, 0, 32'hA000_0000, 2'd0, "R7");
      expect_lk(sva(7, 5), 1, 0, 32'hA000_7000, 2'd0, "R7");
      fill(sva(8, 5), 32'hA000_8000, 2'd0);
      expect_lk(sva(1, 5), 0, 0, 0, 0, "R8");
      expect_lk(sva(0, 5), 1, 0, 32'hA000_0000, 2'd0, "R8");
      expect_lk(sva(8, 5), 1, 0, 32'hA000_8000, 2'd0, "R8");

      // R9: round-robin replacement
      flush();
      lru_en = 0;
      for (int k = 0; k < 8; k++) fill(sva(k, 9), 32'hB000_0000 | (32'(k) << 12), 2'd0);
      expect_lk(sva(0, 9), 1, 0, 32'hB000_0000, 2'd0, "R9");
      fill(sva(8, 9), 32'hB000_8000, 2'd0);
      fill(sva(9, 9), 32'hB000_9000, 2'd0);
      expect_lk(sva(0, 9), 0, 0, 0, 0, "R9");
      expect_lk(sva(1, 9), 0, 0, 0, 0, "R9");
      expect_lk(sva(2, 9), 1, 0, 32'hB000_2000, 2'd0, "R9");

      // R11: fill and lookup hit in the same cycle
      flush();
      lru_en = 1;
      for (int k = 0; k < 8; k++) fill(sva(k, 13), 32'hC000_0000 | (32'(k) << 12), 2'd0);
      step(1, 32'h0001_4000, 32'hD000_0000, 2'd0, 0, 0, 0, 1, sva(0, 13));
      chk(a_hit == 1, "R11", "same-cycle lookup hit", 32'(a_hit), 1);
      fill(sva(8, 13), 32'hC000_8000, 2'd0);
      expect_lk(sva(0, 13), 0, 0, 0, 0, "R11");
      expect_lk(sva(1, 13), 1, 0, 32'hC000_1000, 2'd0, "R11");

      // constrained random against the model
      flush();
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] fva, fpa, lva, ic;
         logic [1:0]  fsz;
         bit fv, lv, iw, fa;
         int r;
         if (n % 500 == 0) lru_en = $urandom % 2;
         fva = {11'd0, 1'($urandom), 2'($urandom), 3'd0, 3'($urandom), 12'($urandom)};
         lva = {11'd0, 1'($urandom), 2'($urandom), 3'd0, 3'($urandom), 12'($urandom)};
         ic  = {11'd0, 1'($urandom), 2'($urandom), 3'd0, 3'($urandom), 11'($urandom), 1'($urandom % 8 != 0)};
         fpa = $urandom;
         r = $urandom % 100;
         fsz = (r < 60) ? 2'd0 : (r < 85) ? 2'd1 : (r < 95) ? 2'd2 : 2'd3;
         fv = ($urandom % 100) < 40;
         lv = ($urandom % 100) < 65;
         iw = ($urandom % 100) < 8;
         fa = ($urandom % 1000) < 6;
         step(fv, fva, fpa, fsz, fa, iw, ic, lv, lva);
         if (lv) begin
            string req;
            req = e_both ? "R11" : e_fault ? "R4" : "R2";
            chk(a_hit == e_hit, req, "random rsp_hit", 32'(a_hit), 32'(e_hit));
            chk(a_fault == e_fault, req, "random rsp_fault", 32'(a_fault), 32'(e_fault));
            if (e_hit) begin
               chk(a_pa == e_pa, req, "random rsp_pa", a_pa, e_pa);
               chk(a_sz == e_sz, req, "random rsp_size", 32'(a_sz), 32'(e_sz));
            end
         end
      end
      idle_inputs();

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule